// File: doc/BRIEF.md
# Register-Mapped Watchdog Countdown Timer

This block is the watchdog and countdown part of a real-time-clock register file. A simple register bus reaches four byte registers. Two are general control registers. One selects the tick rate and the timer mode. The last holds the 8-bit count. A free-running prescaler, clocked by a 32.768 kHz enable input, produces four tick rates. Under the default divider parameters these are 4096 Hz, 64 Hz, 1 Hz and one tick per minute. The counter decrements on the selected tick.

In watchdog mode, the count reaching zero drives an active-low reset output low for one 64 Hz period. Software keeps the system alive by writing a nonzero value to the count register before it runs out. Writing zero stops the timer. There is a deliberate side effect: a read of the status register (address 0x01) while in watchdog mode halts the count, and software must reload it afterwards.

In any other mode the same counter acts as a plain countdown timer. Expiry then sets a sticky flag in the status register and leaves the reset output untouched.

Top module: `rtc_watchdog`

## Requirements
- R1: After reset, all four registers (0x00, 0x01, 0x10, 0x11) read 0x00 and `rstOutN` is high. The counter stays stopped: 0x11 keeps reading 0 and no pulse appears.
- R2: Bits 1:0 of the mode register (0x10) pick the tick period, counted in `oscEn` pulses. Code 00 gives FAST_DIV pulses. Code 01 gives FAST_DIV*MID_DIV. Code 10 gives FAST_DIV*MID_DIV*SLOW_DIV. Code 11 gives that period times MIN_DIV.
- R3: A nonzero write of N to 0x11 loads the counter and starts it. In watchdog mode (0x10 bits 7:6 = 11) with tick period P, with `oscEn` high every cycle, `rstOutN` falls between (N-1)*P+1 and N*P clock cycles after the write edge.
- R4: On expiry in watchdog mode, `rstOutN` stays low for exactly FAST_DIV*MID_DIV `oscEn` pulses. The count then reads 0 and stays at 0 until the next reload.
- R5: Writing 0 to 0x11 stops a running count, and no reset pulse follows.
- R6: Rewriting a nonzero value to 0x11 before expiry restarts the countdown. Repeating this keeps `rstOutN` high indefinitely.
- R7: In watchdog mode, a read of 0x01 halts the count and holds its current value. A later nonzero write to 0x11 resumes the countdown from the new value.
- R8: When 0x10 bits 7:6 are not 11 (countdown mode), expiry sets bit 3 of 0x01 and gives no reset pulse. In this mode a read of 0x01 does not halt the count. Writing 0 to bit 3 clears the flag, and writing 1 to it cannot set it. The other bits of 0x01 read back as written.
- R9: If a write to 0x11 and a tick land in the same cycle, the written value is kept unchanged.
- R10: Registers 0x00 and 0x10 read back the values written to them. Register 0x11 reads the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscEn | input | 1 | One-cycle enable pulse at the 32.768 kHz oscillator rate |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (drives the read side effect) |
| busAddr | input | 5 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| rstOutN | output | 1 | Active-low reset pulse on watchdog expiry |

## Verification
The bench times each expiry against the selected tick period.

- A swapped rate code would move the reset edge outside its window.
- An off-by-one reload would move it by a whole period.
- A pulse of the wrong length would show up as a wrong low-time count.

Repeated writes to 0x11 across several tick edges, each read back before the next edge, catch a design that lets the tick win over the write: it would read N-1. Reads of 0x01 in both modes separate a halt that ignores the mode from one that never happens. A frozen count, or a count that still expires in countdown mode, shows the difference. Writes of 1 to the sticky flag catch a flag that software can set.

// File: rtl/rtc_wdt_pkg.sv
package rtc_wdt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 5'h10;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 5'h11;

  localparam int FLAG_BIT = 3;

  typedef enum logic [1:0] {
    TICK_FAST = 2'b00,
    TICK_MID  = 2'b01,
    TICK_SEC  = 2'b10,
    TICK_MIN  = 2'b11
  } tickSel_t;

  typedef struct packed {
    logic              load;
    logic              halt;
    logic [DATA_W-1:0] data;
  } wdtStb_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler import rtc_wdt_pkg::*; #(
  parameter int unsigned FAST_DIV = 8,
  parameter int unsigned MID_DIV  = 64,
  parameter int unsigned SLOW_DIV = 64,
  parameter int unsigned MIN_DIV  = 60
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     oscEn,
  input  tickSel_t tickSel,
  output logic     tick
);
  localparam int unsigned DIVS [4] = '{FAST_DIV, MID_DIV, SLOW_DIV, MIN_DIV};

  logic [3:0] stageIn;
  logic [3:0] tickRaw;
  logic [3:0] tickQ;

  for (genvar g = 0; g < 4; g++) begin : gStage
    localparam int unsigned D = DIVS[g];
    localparam int W = (D > 1) ? $clog2(D) : 1;
    logic [W-1:0] divCnt;

    if (g == 0) begin : gFirst
      assign stageIn[g] = oscEn;
    end else begin : gNext
      assign stageIn[g] = tickRaw[g-1];
    end

    assign tickRaw[g] = stageIn[g] && (divCnt == W'(D - 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        divCnt <= '0;
      end else if (stageIn[g]) begin
        if (divCnt == W'(D - 1)) divCnt <= '0;
        else                     divCnt <= divCnt + 1'b1;
      end
    end

    // R2
    stage_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      tickRaw[g] |=> (divCnt == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickQ <= '0;
    else       tickQ <= tickRaw;
  end

  assign tick = tickQ[tickSel];
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl import rtc_wdt_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              cdExpire,
  output logic [DATA_W-1:0] busRdData,
  output tickSel_t          tickSel,
  output logic              wdMode,
  output wdtStb_t           stb
);
  logic [DATA_W-1:0] cfgReg;
  logic [DATA_W-1:0] statReg;
  logic [DATA_W-1:0] modeReg;

  logic wrCfg, wrStat, wrMode, wrCnt, rdStat;

  assign wrCfg  = busWrEn && (busAddr == ADDR_CFG);
  assign wrStat = busWrEn && (busAddr == ADDR_STAT);
  assign wrMode = busWrEn && (busAddr == ADDR_MODE);
  assign wrCnt  = busWrEn && (busAddr == ADDR_CNT);
  assign rdStat = busRdEn && (busAddr == ADDR_STAT);

  assign wdMode  = (modeReg[7:6] == 2'b11);
  assign tickSel = tickSel_t'(modeReg[1:0]);

  always_comb begin
    stb.load = wrCnt;
    stb.halt = rdStat && wdMode;
    stb.data = busWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      statReg <= '0;
      modeReg <= '0;
    end else begin
      if (wrCfg)  cfgReg  <= busWrData;
      if (wrMode) modeReg <= busWrData;
      if (wrStat) begin
        statReg <= busWrData;
        statReg[FLAG_BIT] <= (busWrData[FLAG_BIT] & statReg[FLAG_BIT]) | cdExpire;
      end else if (cdExpire) begin
        statReg[FLAG_BIT] <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CFG:  busRdData = cfgReg;
      ADDR_STAT: busRdData = statReg;
      ADDR_MODE: busRdData = modeReg;
      ADDR_CNT:  busRdData = cntVal;
      default:   busRdData = '0;
    endcase
  end

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    cdExpire |=> statReg[FLAG_BIT]);

  // R8
  flag_noset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && !statReg[FLAG_BIT] && !cdExpire) |=> !statReg[FLAG_BIT]);

  // R7
  halt_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.halt |-> (modeReg[7:6] == 2'b11));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath import rtc_wdt_pkg::*; #(
  parameter int unsigned PULSE_LEN = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscEn,
  input  logic              tick,
  input  logic              wdMode,
  input  wdtStb_t           stb,
  output logic [DATA_W-1:0] cntVal,
  output logic              cdExpire,
  output logic              rstOutN
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          running;
  logic          expire;
  logic [PW-1:0] pulseCnt;

  assign expire   = !stb.load && !stb.halt && tick && running && (cntVal == 8'd1);
  assign cdExpire = expire && !wdMode;
  assign rstOutN  = (pulseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal  <= '0;
      running <= 1'b0;
    end else if (stb.load) begin
      cntVal  <= stb.data;
      running <= (stb.data != '0);
    end else if (stb.halt) begin
      running <= 1'b0;
    end else if (tick && running) begin
      cntVal <= cntVal - 1'b1;
      if (cntVal == 8'd1) running <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (expire && wdMode) begin
      pulseCnt <= PW'(PULSE_LEN);
    end else if (oscEn && (pulseCnt != '0)) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (cntVal == $past(stb.data)));

  // R5
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && (stb.data == '0)) |=> !running);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !stb.load && !stb.halt) |=>
      ((cntVal == $past(cntVal)) || (cntVal == $past(cntVal) - 8'd1)));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.halt && !stb.load) |=> (!running && (cntVal == $past(cntVal))));

  // R4
  expire_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> ((cntVal == '0) && !running));

  // R8
  pulse_wd_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOutN) |-> $past(wdMode));
endmodule

// File: rtl/rtc_watchdog.sv
module rtc_watchdog import rtc_wdt_pkg::*; #(
  parameter int unsigned FAST_DIV = 8,
  parameter int unsigned MID_DIV  = 64,
  parameter int unsigned SLOW_DIV = 64,
  parameter int unsigned MIN_DIV  = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscEn,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              rstOutN
);
  localparam int unsigned PULSE_LEN = FAST_DIV * MID_DIV;

  tickSel_t          tickSel;
  logic              wdMode;
  logic              tick;
  logic              cdExpire;
  logic [DATA_W-1:0] cntVal;
  wdtStb_t           stb;

  wdt_prescaler #(
    .FAST_DIV(FAST_DIV), .MID_DIV(MID_DIV),
    .SLOW_DIV(SLOW_DIV), .MIN_DIV(MIN_DIV)
  ) prescaler_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .tickSel(tickSel), .tick(tick)
  );

  wdt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .cntVal(cntVal),
    .cdExpire(cdExpire), .busRdData(busRdData), .tickSel(tickSel),
    .wdMode(wdMode), .stb(stb)
  );

  wdt_datapath #(.PULSE_LEN(PULSE_LEN)) datapath_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .tick(tick), .wdMode(wdMode),
    .stb(stb), .cntVal(cntVal), .cdExpire(cdExpire), .rstOutN(rstOutN)
  );
endmodule

// File: tb/rtc_watchdog_tb_top.sv
module rtc_watchdog_tb_top;
  localparam int FAST_DIV = 8;
  localparam int MID_DIV  = 64;
  localparam int SLOW_DIV = 4;
  localparam int MIN_DIV  = 3;
  localparam int PULSE    = FAST_DIV * MID_DIV;
  localparam int NVEC     = 6;

  localparam logic [1:0] VSEL [NVEC] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam int         VN   [NVEC] = '{5, 1, 255, 2, 3, 2};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscEn = 1'b0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       rstOutN;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  rtc_watchdog #(
    .FAST_DIV(FAST_DIV), .MID_DIV(MID_DIV),
    .SLOW_DIV(SLOW_DIV), .MIN_DIV(MIN_DIV)
  ) dut_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .rstOutN(rstOutN)
  );

  function automatic int period(input logic [1:0] sel);
    case (sel)
      2'd0:    period = FAST_DIV;
      2'd1:    period = FAST_DIV * MID_DIV;
      2'd2:    period = FAST_DIV * MID_DIV * SLOW_DIV;
      default: period = FAST_DIV * MID_DIV * SLOW_DIV * MIN_DIV;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n, output bit sawLow);
    sawLow = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!rstOutN) sawLow = 1'b1;
    end
  endtask

  task automatic waitHigh();
    for (int i = 0; i < 4 * PULSE && !rstOutN; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd, v1, v2;
    bit low;
    int n, w, p, lim;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    oscEn = 1'b1;

    // R1: reset state
    busRead(5'h00, rd); chk(rd == 8'h00, "R1 cfg", rd, 0);
    busRead(5'h01, rd); chk(rd == 8'h00, "R1 stat", rd, 0);
    busRead(5'h10, rd); chk(rd == 8'h00, "R1 mode", rd, 0);
    busRead(5'h11, rd); chk(rd == 8'h00, "R1 cnt", rd, 0);
    idle(100, low);
    chk(!low, "R1 no pulse after reset", low, 0);
    busRead(5'h11, rd); chk(rd == 8'h00, "R1 cnt stopped", rd, 0);

    // R10: readback
    busWrite(5'h00, 8'hA5); busRead(5'h00, rd);
    chk(rd == 8'hA5, "R10 cfg readback", rd, 8'hA5);
    busWrite(5'h10, 8'hC2); busRead(5'h10, rd);
    chk(rd == 8'hC2, "R10 mode readback", rd, 8'hC2);

    // R2 R3 R4: vector table of rate code and timeout
    for (int v = 0; v < NVEC; v++) begin
      p = period(VSEL[v]);
      busWrite(5'h10, {6'b110000, VSEL[v]});
      busWrite(5'h11, 8'(VN[v]));
      lim = VN[v] * p + 10;
      n = 0;
      while (rstOutN && n < lim) begin
        @(negedge clk);
        n++;
      end
      chk(n >= (VN[v] - 1) * p + 1 && n <= VN[v] * p,
          $sformatf("R2 R3 timeout sel=%0d N=%0d", VSEL[v], VN[v]), n, VN[v] * p);
      w = 1;
      while (w < 4 * PULSE) begin
        @(negedge clk);
        if (!rstOutN) w++;
        else break;
      end
      chk(w == PULSE, "R4 pulse width", w, PULSE);
      busRead(5'h11, rd); chk(rd == 8'h00, "R4 cnt zero after expiry", rd, 0);
    end

    // R4: no restart after expiry
    idle(200, low);
    chk(!low, "R4 stays stopped", low, 0);

    // R5: zero write stops
    busWrite(5'h10, 8'hC0);
    busWrite(5'h11, 8'd4);
    idle(10, low);
    busWrite(5'h11, 8'd0);
    idle(100, low);
    chk(!low, "R5 zero write stops", low, 0);
    busRead(5'h11, rd); chk(rd == 8'h00, "R5 cnt zero", rd, 0);

    // R6: keep-alive
    low = 1'b0;
    for (int k = 0; k < 12; k++) begin
      bit l2;
      busWrite(5'h11, 8'd4);
      idle(20, l2);
      low = low | l2;
    end
    chk(!low, "R6 keep-alive holds reset high", low, 0);

    // R9: write wins over a coincident tick
    w = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      busAddr = 5'h11; busWrData = 8'd9; busWrEn = 1'b1;
      @(negedge clk);
      #1 if (busRdData != 8'd9) w++;
    end
    busWrEn = 1'b0;
    chk(w == 0, "R9 write wins over tick", w, 0);
    busWrite(5'h11, 8'd0);

    // R7: status read halts in watchdog mode
    busWrite(5'h11, 8'd200);
    idle(40, low);
    busRead(5'h01, rd);
    busRead(5'h11, v1);
    idle(60, low);
    busRead(5'h11, v2);
    chk(v1 == v2 && v1 != 8'd200 && v1 != 0, "R7 halt freezes count", v2, v1);
    busWrite(5'h11, 8'd3);
    n = 0;
    while (rstOutN && n < 40) begin @(negedge clk); n++; end
    chk(n >= 17 && n <= 24, "R7 reload resumes", n, 24);
    waitHigh();

    // R8: countdown mode
    busWrite(5'h10, 8'h00);
    busWrite(5'h11, 8'd3);
    idle(60, low);
    chk(!low, "R8 no pulse in countdown", low, 0);
    busRead(5'h01, rd); chk(rd[3] == 1'b1, "R8 flag set", rd[3], 1);
    busWrite(5'h01, 8'h00); busRead(5'h01, rd);
    chk(rd == 8'h00, "R8 flag clear", rd, 0);
    busWrite(5'h01, 8'h08); busRead(5'h01, rd);
    chk(rd == 8'h00, "R8 flag not settable", rd, 0);
    busWrite(5'h01, 8'h37); busRead(5'h01, rd);
    chk(rd == 8'h37, "R8 other bits stored", rd, 8'h37);
    busWrite(5'h01, 8'h00);
    busWrite(5'h11, 8'd5);
    idle(8, low);
    busRead(5'h01, rd);
    idle(60, low);
    busRead(5'h11, rd); chk(rd == 8'h00, "R8 status read does not halt", rd, 0);
    busRead(5'h01, rd); chk(rd[3] == 1'b1, "R8 flag after unhalted run", rd[3], 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule